// File: doc/BRIEF.md
# Fine-Grained Translation Invalidation Decoder

This unit sits beside the main instruction decoder. It watches each issued 32-bit instruction word and claims three SYSTEM-opcode instructions used for fine-grained address-translation invalidation:

- a write-ordering fence;
- an instruction-side ordering fence;
- a page-invalidate form that names an address register and an address-space-identifier register.

For every claimed word it decides, from the current privilege level and the trap-virtual-memory bit, whether the instruction traps as illegal or retires. A page invalidate that retires also sends a single-cycle flush request toward the TLB. That request carries optional address and ASID qualifiers. A source index of zero turns the matching qualifier into a match-all wildcard.

Words that are not one of the three encodings get a "not mine" pulse, so other decoders can take them. The same happens for all three encodings while the extension-enable input is low. All outputs are registered and appear one clock after the issue cycle. Ordering effects of the two fences are shown only as a retire pulse.

Top module: `tlb_inval_decode`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every output is 0.
- R2: A word is claimed only when all of the following hold: bits [6:0] are 1110011, bits [14:12] are 000 and bits [11:7] are 00000. In addition, one of these must match:
  - write fence: bits [31:25] are 0001100, bits [24:20] are 00001 and bits [19:15] are 00000;
  - instruction fence: bits [31:25] are 0001100, bits [24:20] are 00000 and bits [19:15] are 00000;
  - page invalidate: bits [31:25] are 0001011, with any register indices.
- R3: With privilege 00 (User), each claimed word raises `illegal` and never `retire` or `flush_valid`.
- R4: Privilege code 10 is not a valid level; each claimed word under it raises `illegal`.
- R5: Both fence forms raise `retire`, with no flush, under privilege 01 (Supervisor) or 11 (Machine), whatever the value of `tvm`.
- R6: A page invalidate under Supervisor with `tvm`=1 raises `illegal` and no flush.
- R7: A page invalidate under Supervisor with `tvm`=0, or under Machine with any `tvm`, raises `retire` and `flush_valid` in the same cycle.
- R8: On a flush, `flush_addr_valid` is 0 and `flush_addr` is 0 when the rs1 index (bits [19:15]) is zero. Otherwise `flush_addr_valid` is 1 and `flush_addr` equals `rs1_val`.
- R9: On a flush, `flush_asid_valid` is 0 and `flush_asid` is 0 when the rs2 index (bits [24:20]) is zero. Otherwise `flush_asid_valid` is 1 and `flush_asid` equals the low ASID_W bits of `rs2_val`.
- R10: While `ext_en` is 0, the three encodings raise only `not_mine`.
- R11: An issued word that is not claimed raises only `not_mine`.
- R12: Each result is a one-cycle pulse one clock after `instr_valid`. A cycle after one with `instr_valid` low shows all outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Enables recognition of the three encodings |
| instr_valid | input | 1 | An instruction is issued this cycle |
| instr | input | 32 | Instruction word |
| priv | input | 2 | Privilege: 00 User, 01 Supervisor, 11 Machine, 10 invalid |
| tvm | input | 1 | Trap-virtual-memory bit from the status register |
| rs1_val | input | XLEN | Value read from the rs1 register |
| rs2_val | input | XLEN | Value read from the rs2 register |
| illegal | output | 1 | Illegal-instruction pulse |
| retire | output | 1 | Successful-retire pulse |
| not_mine | output | 1 | Word left for other decoders |
| flush_valid | output | 1 | TLB flush request pulse |
| flush_addr_valid | output | 1 | Address qualifier present |
| flush_addr | output | XLEN | Address qualifier |
| flush_asid_valid | output | 1 | ASID qualifier present |
| flush_asid | output | ASID_W | ASID qualifier |

## Verification
The bench builds the unit with XLEN=64 and ASID_W=9. The narrow ASID lets a wide `rs2_val` with set upper bits show that only the low bits reach `flush_asid`, which exercises the truncating variant of the qualifier logic. The 64-bit address path carries a value with both halves non-zero, so a dropped upper half in the address qualifier is caught.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_WFENCE = 2'd1,
    KIND_IFENCE = 2'd2,
    KIND_PAGE   = 2'd3
  } inval_kind_e;

  localparam logic [1:0] PRIV_USER  = 2'b00;
  localparam logic [1:0] PRIV_SUPER = 2'b01;
  localparam logic [1:0] PRIV_MACH  = 2'b11;

  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [2:0] F3_PRIV    = 3'b000;
  localparam logic [6:0] F7_FENCE   = 7'b0001100;
  localparam logic [6:0] F7_PAGE    = 7'b0001011;
  localparam logic [4:0] SEL_WFENCE = 5'b00001;
  localparam logic [4:0] SEL_IFENCE = 5'b00000;

  typedef struct packed {
    logic [4:0] rs2;
    logic [4:0] rs1;
  } src_idx_t;

endpackage

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
(
  input  logic        ext_en,
  input  logic [31:0] instr,
  output inval_kind_e kind,
  output src_idx_t    idx
);

  logic [6:0] opc;
  logic [4:0] rd;
  logic [2:0] f3;
  logic [4:0] f_rs1;
  logic [4:0] f_rs2;
  logic [6:0] f7;
  logic       sys_frame;

  assign opc   = instr[6:0];
  assign rd    = instr[11:7];
  assign f3    = instr[14:12];
  assign f_rs1 = instr[19:15];
  assign f_rs2 = instr[24:20];
  assign f7    = instr[31:25];

  assign sys_frame = ext_en && (opc == OPC_SYSTEM) && (f3 == F3_PRIV) && (rd == 5'd0);

  always_comb begin
    kind = KIND_NONE;
    if (sys_frame) begin
      if (f7 == F7_PAGE) begin
        kind = KIND_PAGE;
      end else if (f7 == F7_FENCE && f_rs1 == 5'd0) begin
        if (f_rs2 == SEL_WFENCE) kind = KIND_WFENCE;
        else if (f_rs2 == SEL_IFENCE) kind = KIND_IFENCE;
      end
    end
  end

  assign idx.rs1 = f_rs1;
  assign idx.rs2 = f_rs2;

endmodule

// File: rtl/tlbinv_perm.sv
module tlbinv_perm
  import tlbinv_pkg::*;
(
  input  inval_kind_e kind,
  input  logic [1:0]  priv,
  input  logic        tvm,
  output logic        trap,
  output logic        ok,
  output logic        do_flush
);

  logic lvl_known;
  logic is_user;
  logic is_super;

  assign lvl_known = (priv == PRIV_USER) || (priv == PRIV_SUPER) || (priv == PRIV_MACH);
  assign is_user   = (priv == PRIV_USER);
  assign is_super  = (priv == PRIV_SUPER);

  always_comb begin
    trap     = 1'b0;
    ok       = 1'b0;
    do_flush = 1'b0;
    unique case (kind)
      KIND_WFENCE, KIND_IFENCE: begin
        trap = !lvl_known || is_user;
        ok   = !trap;
      end
      KIND_PAGE: begin
        trap     = !lvl_known || is_user || (is_super && tvm);
        ok       = !trap;
        do_flush = !trap;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tlbinv_qual.sv
module tlbinv_qual
  import tlbinv_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ASID_W = 16
) (
  input  src_idx_t          idx,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  output logic              addr_valid,
  output logic [XLEN-1:0]   addr,
  output logic              asid_valid,
  output logic [ASID_W-1:0] asid
);

  logic [ASID_W-1:0] asid_src;

  generate
    if (ASID_W < XLEN) begin : g_trunc
      logic unused_hi;
      assign asid_src  = rs2_val[ASID_W-1:0];
      assign unused_hi = ^rs2_val[XLEN-1:ASID_W];
    end else if (ASID_W == XLEN) begin : g_same
      assign asid_src = rs2_val;
    end else begin : g_widen
      assign asid_src = {{(ASID_W-XLEN){1'b0}}, rs2_val};
    end
  endgenerate

  assign addr_valid = (idx.rs1 != 5'd0);
  assign asid_valid = (idx.rs2 != 5'd0);
  assign addr       = addr_valid ? rs1_val  : '0;
  assign asid       = asid_valid ? asid_src : '0;

endmodule

// File: rtl/tlb_inval_decode.sv
module tlb_inval_decode
  import tlbinv_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ASID_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic [1:0]        priv,
  input  logic              tvm,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [XLEN-1:0]   rs2_val,
  output logic              illegal,
  output logic              retire,
  output logic              not_mine,
  output logic              flush_valid,
  output logic              flush_addr_valid,
  output logic [XLEN-1:0]   flush_addr,
  output logic              flush_asid_valid,
  output logic [ASID_W-1:0] flush_asid
);

  inval_kind_e       kind;
  src_idx_t          idx;
  logic              trap;
  logic              ok;
  logic              do_flush;
  logic              q_addr_v;
  logic [XLEN-1:0]   q_addr;
  logic              q_asid_v;
  logic [ASID_W-1:0] q_asid;
  logic              claimed;
  logic              fire;

  tlbinv_match u_match (
    .ext_en (ext_en),
    .instr  (instr),
    .kind   (kind),
    .idx    (idx)
  );

  tlbinv_perm u_perm (
    .kind     (kind),
    .priv     (priv),
    .tvm      (tvm),
    .trap     (trap),
    .ok       (ok),
    .do_flush (do_flush)
  );

  tlbinv_qual #(
    .XLEN   (XLEN),
    .ASID_W (ASID_W)
  ) u_qual (
    .idx        (idx),
    .rs1_val    (rs1_val),
    .rs2_val    (rs2_val),
    .addr_valid (q_addr_v),
    .addr       (q_addr),
    .asid_valid (q_asid_v),
    .asid       (q_asid)
  );

  assign claimed = (kind != KIND_NONE);
  assign fire    = instr_valid && do_flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal          <= 1'b0;
      retire           <= 1'b0;
      not_mine         <= 1'b0;
      flush_valid      <= 1'b0;
      flush_addr_valid <= 1'b0;
      flush_addr       <= '0;
      flush_asid_valid <= 1'b0;
      flush_asid       <= '0;
    end else begin
      illegal          <= instr_valid && claimed && trap;
      retire           <= instr_valid && claimed && ok;
      not_mine         <= instr_valid && !claimed;
      flush_valid      <= fire;
      flush_addr_valid <= fire && q_addr_v;
      flush_addr       <= fire ? q_addr : '0;
      flush_asid_valid <= fire && q_asid_v;
      flush_asid       <= fire ? q_asid : '0;
    end
  end

endmodule

// File: rtl/tlbinv_decode_chk.sv
module tlbinv_decode_chk #(
  parameter int XLEN   = 64,
  parameter int ASID_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ext_en,
  input logic            instr_valid,
  input logic [1:0]      priv,
  input logic            tvm,
  input logic            illegal,
  input logic            retire,
  input logic            not_mine,
  input logic            flush_valid,
  input logic            flush_addr_valid,
  input logic [XLEN-1:0] flush_addr
);

  // R2
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({illegal, retire, not_mine}));

  // R7
  flush_retires_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> retire);

  // R3
  user_no_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && priv == 2'b00) |=> (!retire && !flush_valid));

  // R6
  tvm_blocks_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && priv == 2'b01 && tvm) |=> !flush_valid);

  // R8
  addr_wild_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_addr_valid |-> (flush_addr == '0));

  // R10
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !ext_en) |=> (not_mine && !illegal && !retire));

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !(illegal || retire || not_mine || flush_valid));

endmodule

bind tlb_inval_decode tlbinv_decode_chk #(
  .XLEN   (XLEN),
  .ASID_W (ASID_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .ext_en           (ext_en),
  .instr_valid      (instr_valid),
  .priv             (priv),
  .tvm              (tvm),
  .illegal          (illegal),
  .retire           (retire),
  .not_mine         (not_mine),
  .flush_valid      (flush_valid),
  .flush_addr_valid (flush_addr_valid),
  .flush_addr       (flush_addr)
);

// File: tb/test_tlb_inval_decode.sv
module test_tlb_inval_decode;

  localparam int XLEN   = 64;
  localparam int ASID_W = 9;
  localparam int NV     = 17;

  localparam logic [31:0] W_FENCE = 32'h18100073;
  localparam logic [31:0] I_FENCE = 32'h18000073;
  localparam logic [31:0] PAGE_AB = 32'h16550073;  // rs2=x5, rs1=x10

  // {ext_en, priv, tvm, instr, ill, ret, nm, fl, req}
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 2'b00, 1'b0, W_FENCE,      4'b1000, 4'd3},   // R3
    {1'b1, 2'b01, 1'b0, W_FENCE,      4'b0100, 4'd5},   // R5
    {1'b1, 2'b01, 1'b1, W_FENCE,      4'b0100, 4'd5},
    {1'b1, 2'b11, 1'b1, I_FENCE,      4'b0100, 4'd5},
    {1'b1, 2'b00, 1'b0, I_FENCE,      4'b1000, 4'd3},
    {1'b1, 2'b10, 1'b0, I_FENCE,      4'b1000, 4'd4},   // R4
    {1'b1, 2'b00, 1'b0, PAGE_AB,      4'b1000, 4'd3},
    {1'b1, 2'b01, 1'b1, PAGE_AB,      4'b1000, 4'd6},   // R6
    {1'b1, 2'b01, 1'b0, PAGE_AB,      4'b0101, 4'd7},   // R7
    {1'b1, 2'b11, 1'b1, PAGE_AB,      4'b0101, 4'd7},
    {1'b1, 2'b10, 1'b0, PAGE_AB,      4'b1000, 4'd4},
    {1'b0, 2'b11, 1'b0, PAGE_AB,      4'b0010, 4'd10},  // R10
    {1'b0, 2'b01, 1'b0, W_FENCE,      4'b0010, 4'd10},
    {1'b1, 2'b11, 1'b0, 32'h12000073, 4'b0010, 4'd11},  // R11
    {1'b1, 2'b11, 1'b0, 32'h181000F3, 4'b0010, 4'd2},   // R2 rd non-zero
    {1'b1, 2'b11, 1'b0, 32'h18101073, 4'b0010, 4'd2},   // R2 funct3 non-zero
    {1'b1, 2'b11, 1'b0, 32'h18200073, 4'b0010, 4'd2}    // R2 fence selector 2
  };

  localparam logic [XLEN-1:0] RS1_V = 64'h1234_5678_9ABC_D000;
  localparam logic [XLEN-1:0] RS2_V = 64'hFFFF_0000_0000_0ABC;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ext_en = 1'b0;
  logic              instr_valid = 1'b0;
  logic [31:0]       instr = '0;
  logic [1:0]        priv = '0;
  logic              tvm = 1'b0;
  logic [XLEN-1:0]   rs1_val = RS1_V;
  logic [XLEN-1:0]   rs2_val = RS2_V;
  logic              illegal, retire, not_mine, flush_valid;
  logic              flush_addr_valid, flush_asid_valid;
  logic [XLEN-1:0]   flush_addr;
  logic [ASID_W-1:0] flush_asid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tlb_inval_decode #(.XLEN(XLEN), .ASID_W(ASID_W)) i_tlb_inval_decode (
    .clk (clk), .rst (rst), .ext_en (ext_en), .instr_valid (instr_valid),
    .instr (instr), .priv (priv), .tvm (tvm), .rs1_val (rs1_val), .rs2_val (rs2_val),
    .illegal (illegal), .retire (retire), .not_mine (not_mine),
    .flush_valid (flush_valid), .flush_addr_valid (flush_addr_valid),
    .flush_addr (flush_addr), .flush_asid_valid (flush_asid_valid),
    .flush_asid (flush_asid)
  );

  function automatic logic [31:0] page_word(input logic [4:0] r2, input logic [4:0] r1);
    return {7'b0001011, r2, r1, 3'b000, 5'b00000, 7'b1110011};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_all(input string tag);
    chk(tag, "idle outputs",
        {59'd0, illegal, retire, not_mine, flush_valid, flush_addr_valid}, 64'd0);
    chk(tag, "idle addr", flush_addr, 64'd0);
    chk(tag, "idle asid", {54'd0, flush_asid_valid, flush_asid}, 64'd0);
  endtask

  // drive at a falling edge, sample at the next falling edge (one register)
  task automatic issue(input logic e, input logic [1:0] p, input logic t,
                       input logic [31:0] w);
    @(negedge clk);
    ext_en = e; priv = p; tvm = t; instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low, also with an instruction presented
    ext_en = 1'b1; priv = 2'b11; instr = W_FENCE; instr_valid = 1'b1;
    repeat (3) @(negedge clk);
    idle_all("R1");
    instr_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_all("R1");

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [3:0] ex;
      tag = $sformatf("R%0d", VEC[i][3:0]);
      ex  = VEC[i][7:4];
      issue(VEC[i][43], VEC[i][42:41], VEC[i][40], VEC[i][39:8]);
      chk(tag, $sformatf("vec%0d ill/ret/nm/fl", i),
          {60'd0, illegal, retire, not_mine, flush_valid}, {60'd0, ex});
      if (ex[0]) begin
        chk("R8", $sformatf("vec%0d addr", i), {flush_addr_valid, flush_addr[62:0]},
            {1'b1, RS1_V[62:0]});
        chk("R9", $sformatf("vec%0d asid", i), {54'd0, flush_asid_valid, flush_asid},
            {54'd0, 1'b1, RS2_V[ASID_W-1:0]});
      end
      @(negedge clk);
      idle_all("R12");
    end

    // R8 / R9: wildcard qualifiers
    issue(1'b1, 2'b11, 1'b0, page_word(5'd0, 5'd0));
    chk("R7", "flush both wild", {63'd0, flush_valid}, 64'd1);
    chk("R8", "addr wild", {flush_addr_valid, flush_addr[62:0]}, 64'd0);
    chk("R9", "asid wild", {54'd0, flush_asid_valid, flush_asid}, 64'd0);
    issue(1'b1, 2'b01, 1'b0, page_word(5'd0, 5'd31));
    chk("R8", "addr given", {flush_addr_valid, flush_addr[62:0]}, {1'b1, RS1_V[62:0]});
    chk("R8", "addr top bit", {63'd0, flush_addr[63]}, {63'd0, RS1_V[63]});
    chk("R9", "asid wild only", {54'd0, flush_asid_valid, flush_asid}, 64'd0);
    issue(1'b1, 2'b11, 1'b1, page_word(5'd1, 5'd0));
    chk("R8", "addr wild only", {flush_addr_valid, flush_addr[62:0]}, 64'd0);
    chk("R9", "asid truncated", {54'd0, flush_asid_valid, flush_asid},
        {54'd0, 1'b1, RS2_V[ASID_W-1:0]});

    // R12: back-to-back issues each give their own pulse
    @(negedge clk);
    ext_en = 1'b1; priv = 2'b00; tvm = 1'b0; instr = I_FENCE; instr_valid = 1'b1;
    @(negedge clk);
    chk("R12", "b2b first", {61'd0, illegal, retire, not_mine}, 64'b100);
    priv = 2'b11;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R12", "b2b second", {61'd0, illegal, retire, not_mine}, 64'b010);
    @(negedge clk);
    idle_all("R12");

    // R1: reset in the middle of a pulse clears it
    @(negedge clk);
    priv = 2'b11; instr = page_word(5'd3, 5'd4); instr_valid = 1'b1;
    @(posedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
    idle_all("R1");
    rst = 1'b0;
    @(negedge clk);
    idle_all("R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule